// File: doc/BRIEF.md
# Programmable Network Activity LED Driver

This block turns a handful of network status events into the drive for a single activity LED pin. The events are collision, jabber, receive activity, receive polarity reversed, transmit activity and address-matched receive. A host-programmable control register holds one enable bit per event, and the LED condition is the OR of every enabled event. Link status gates the polarity event. A port-select input arms a masking window that hides collisions for a fixed time after each transmit ends, because the attachment unit reports its heartbeat test as a collision.

The condition can be lengthened by a pulse stretcher. It then reaches the pin through an output stage. That stage gives either an inverted open-drain output (an output enable plus a low drive level) or a totem-pole output that follows the condition directly. A disable bit forces the pin to its inactive level. The host can read back the live, unstretched condition as a read-only bit at any time.

Top module: `led_status_driver`

## Requirements
- R1: After hard reset the register reads 0x0000_0090 while no enabled event is present. Only bits 0-5, 7, 13 and 14 are writable. Bit 15 ignores writes, and every other bit reads 0.
- R2: Register bits 0..5 enable, in this order, collision, jabber, receive activity, receive polarity reversed, transmit activity and address-matched receive. The LED condition is the OR of all enabled events.
- R3: Register bit 14 selects the pin type. At 0 (open drain) the pin has led_oe=1 and led_drive=0 while active, and led_oe=0 while inactive. At 1 (totem pole) led_oe is always 1 and led_drive equals the active state.
- R4: Read bit 15 equals the current unstretched condition in the same cycle, whatever the value of bit 14, the stretcher or the disable bit.
- R5: While register bit 13 is 1, the pin stays at its inactive level for the selected type, whatever events are present.
- R6: The receive polarity event counts only while link_pass is 1.
- R7: With aui_sel=1, a collision has no effect from the first cycle in which tx_active is low after being high, through SQE_CYCLES cycles in total, and only while tx_active stays low. With aui_sel=0, no masking applies.
- R8: With register bit 7 set, each rising edge of the condition keeps the pin active in that cycle and for STRETCH_CYCLES further cycles. Any new rising edge restarts the hold. With bit 7 clear, the pin follows the condition directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data (live) |
| ev_collision | input | 1 | Collision activity |
| ev_jabber | input | 1 | Jabber condition |
| ev_rx_active | input | 1 | Receive activity |
| ev_rx_pol_rev | input | 1 | Receive pair polarity reversed |
| ev_tx_active | input | 1 | Transmit activity |
| ev_rx_addr_match | input | 1 | Received frame passed address match |
| link_pass | input | 1 | Link status is PASS |
| aui_sel | input | 1 | Attachment unit port selected |
| led_drive | output | 1 | Level driven on the pin when enabled |
| led_oe | output | 1 | Pin output enable (0 = floating) |

## Verification
The bench builds the block with STRETCH_CYCLES=6 and SQE_CYCLES=5, so that both timing windows finish within a few cycles. This lets the bench reach the exact first and last masked collision cycle, a restart of the stretch just before it runs out, and the point where the stretch expires while the condition is still high. A behavioural model built on cycle stamps predicts the read data and both pin signals in every cycle. It runs through register writes, all 64 event patterns under several enable masks, both pin types, disable, link gating and the masking window.

// File: rtl/led_status_driver.sv
module led_status_driver #(
  parameter int STRETCH_CYCLES = 2_500_000,
  parameter int SQE_CYCLES     = 200_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        ev_collision,
  input  logic        ev_jabber,
  input  logic        ev_rx_active,
  input  logic        ev_rx_pol_rev,
  input  logic        ev_tx_active,
  input  logic        ev_rx_addr_match,
  input  logic        link_pass,
  input  logic        aui_sel,
  output logic        led_drive,
  output logic        led_oe
);
  localparam int HW = $clog2(STRETCH_CYCLES + 1);
  localparam int SW = $clog2(SQE_CYCLES + 1);

  logic [5:0]    ev_en;
  logic          stretch_en, led_dis, led_pol;
  logic          tx_q, cond_q;
  logic [SW-1:0] sqe_cnt;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev_en      <= 6'h10;
      stretch_en <= 1'b1;
      led_dis    <= 1'b0;
      led_pol    <= 1'b0;
    end else if (reg_wr_en) begin
      ev_en      <= reg_wr_data[5:0];
      stretch_en <= reg_wr_data[7];
      led_dis    <= reg_wr_data[13];
      led_pol    <= reg_wr_data[14];
    end

  wire tx_fall  = tx_q & ~ev_tx_active;
  wire col_mask = aui_sel & ~ev_tx_active & (tx_fall | (sqe_cnt != '0));

  wire [5:0] ev_vec = {ev_rx_addr_match, ev_tx_active, ev_rx_pol_rev & link_pass,
                       ev_rx_active, ev_jabber, ev_collision & ~col_mask};
  wire cond = |(ev_vec & ev_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_q    <= 1'b0;
      sqe_cnt <= '0;
    end else begin
      tx_q <= ev_tx_active;
      if (ev_tx_active)          sqe_cnt <= '0;
      else if (tx_fall)          sqe_cnt <= SW'(SQE_CYCLES - 1);
      else if (sqe_cnt != '0)    sqe_cnt <= sqe_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cond_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      cond_q <= cond;
      if (cond & ~cond_q)        hold_cnt <= HW'(STRETCH_CYCLES);
      else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
    end

  wire led_active = ~led_dis & (cond | (stretch_en & (hold_cnt != '0)));

  assign led_oe      = led_pol | led_active;
  assign led_drive   = led_pol & led_active;
  assign reg_rd_data = {16'h0, cond, led_pol, led_dis, 5'b0, stretch_en, 1'b0, ev_en};

  assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_pol && led_oe) |-> !led_drive) else $error("open-drain pin driven high");

  assert_dis_od_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (led_dis && !led_pol) |-> !led_oe) else $error("disabled open-drain pin enabled");

  assert_dis_tp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (led_dis && led_pol) |-> (led_oe && !led_drive)) else $error("disabled totem pin active");

  assert_sqe_masks_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (aui_sel && $fell(ev_tx_active) && ev_en == 6'b000001) |-> !reg_rd_data[15])
    else $error("collision visible at start of masking window");

  assert_stretch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_rd_data[15]) && stretch_en && !led_dis) |=> (led_active || !stretch_en || led_dis))
    else $error("stretch did not hold pin active");
endmodule

// File: tb/test_led_status_driver.sv
`timescale 1ns/1ps
module test_led_status_driver;
  localparam int STR = 6;
  localparam int SQE = 5;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic [5:0] ev = 0;
  logic link_pass = 0, aui_sel = 0;
  logic led_drive, led_oe;

  always #2.5 clk = ~clk;

  led_status_driver #(.STRETCH_CYCLES(STR), .SQE_CYCLES(SQE)) i_led_status_driver (
    .clk, .rst_n, .reg_wr_en, .reg_wr_data, .reg_rd_data,
    .ev_collision(ev[0]), .ev_jabber(ev[1]), .ev_rx_active(ev[2]),
    .ev_rx_pol_rev(ev[3]), .ev_tx_active(ev[4]), .ev_rx_addr_match(ev[5]),
    .link_pass, .aui_sel, .led_drive, .led_oe);

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model: cycle stamps instead of counters
  longint cyc = 0, fall_cyc = -1000, rise_cyc = -1000;
  bit prev_tx = 0, prev_cond = 0;
  int m_reg = 32'h90;

  function automatic bit m_cond();
    bit masked;
    bit [5:0] e;
    masked = aui_sel && !ev[4] && (cyc - fall_cyc < SQE);
    e = ev;
    if (masked) e[0] = 0;
    if (!link_pass) e[3] = 0;
    return |(e & m_reg[5:0]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 32'h90; prev_tx = 0; prev_cond = 0; fall_cyc = -1000; rise_cyc = -1000;
    end else begin
      prev_cond = m_cond();
      prev_tx = ev[4];
      if (reg_wr_en) m_reg = reg_wr_data & 32'h60BF;
    end
    cyc++;
  end

  always @(negedge clk) if (!done) begin
    bit c, act;
    logic [1:0] pin;
    if (rst_n && prev_tx && !ev[4]) fall_cyc = cyc;
    c = m_cond();
    if (rst_n && c && !prev_cond) rise_cyc = cyc;
    act = !m_reg[13] && (c || (m_reg[7] && (cyc - rise_cyc <= STR)));
    pin = m_reg[14] ? {1'b1, act} : {act, 1'b0};
    chk(tag, reg_rd_data, m_reg | (c << 15));
    chk(tag, {led_oe, led_drive}, pin);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr_en = 1; reg_wr_data = d; step(1); reg_wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #250000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset value; R4 live bit during reset
    ev = 6'h10; step(3);
    rst_n = 1; ev = 0; step(2);
    chk("R1", reg_rd_data, 32'h0000_0090);
    wr(32'hFFFF_FFFF); step(1);
    chk("R1", reg_rd_data, 32'h0000_60BF);
    wr(32'h0000_8000); step(1);
    chk("R1", reg_rd_data, 32'h0);

    // R2 enable mapping, totem pole, no stretch
    tag = "R2"; link_pass = 1;
    for (int m = 0; m < 6; m++) begin
      wr(32'h4000 | (1 << m));
      for (int p = 0; p < 64; p++) begin ev = p[5:0]; step(1); end
    end
    wr(32'h402D);
    for (int p = 0; p < 64; p++) begin ev = 6'(p * 7); step(1); end

    // R3 open drain vs totem pole
    tag = "R3";
    wr(32'h0002);
    for (int p = 0; p < 8; p++) begin ev = {4'b0, p[0], 1'b0}; step(1); end
    wr(32'h4002);
    for (int p = 0; p < 8; p++) begin ev = {4'b0, p[1], 1'b0}; step(1); end

    // R4 polarity, stretch, disable leave live bit unchanged
    tag = "R4"; ev = 6'h04;
    wr(32'h0004); step(1); chk("R4", reg_rd_data[15], 1);
    wr(32'h6084); step(1); chk("R4", reg_rd_data[15], 1);
    ev = 0; step(1); chk("R4", reg_rd_data[15], 0);

    // R5 disable
    tag = "R5";
    wr(32'h203F); ev = 6'h3F; step(3);
    chk("R5", {led_oe, led_drive}, 2'b00);
    wr(32'h603F); step(2);
    chk("R5", {led_oe, led_drive}, 2'b10);
    ev = 0; step(1);

    // R6 link gating of polarity event
    tag = "R6";
    wr(32'h4008); ev = 6'h08;
    link_pass = 0; step(2); chk("R6", led_drive, 0);
    link_pass = 1; step(2); chk("R6", led_drive, 1);
    link_pass = 0; step(1); ev = 0; link_pass = 1;

    // R7 collision masking window after transmit
    tag = "R7"; aui_sel = 1;
    wr(32'h4001);
    for (int off = 0; off < SQE + 2; off++) begin
      ev = 6'h10; step(3);
      ev = 0; step(off);
      ev = 6'h01; step(1);
      ev = 0; step(1);
    end
    ev = 6'h10; step(2); ev = 6'h01; step(3); ev = 6'h11; step(1); ev = 0; step(2);
    aui_sel = 0;
    ev = 6'h10; step(2); ev = 6'h01; step(2); ev = 0; step(1);
    aui_sel = 1;

    // R8 stretcher
    tag = "R8"; aui_sel = 0;
    wr(32'h4084);
    ev = 6'h04; step(1); ev = 0; step(STR + 3);
    ev = 6'h04; step(1); ev = 0; step(STR - 1);
    ev = 6'h04; step(1); ev = 0; step(STR + 3);
    ev = 6'h04; step(STR + 4); ev = 0; step(STR + 3);
    wr(32'h0084);
    ev = 6'h04; step(2); ev = 0; step(STR + 3);
    wr(32'h4004);
    ev = 6'h04; step(1); ev = 0; step(3);
    chk("R8", led_drive, 0);

    finish_run();
  end
endmodule